// File: doc/BRIEF.md
# Stepped Digital Volume Attenuator

This block applies a volume setting to a two-channel stream of 16-bit signed audio samples. The gain comes from a 7-bit level counter. A level of 127 passes the signal unchanged and a level of 0 silences it. In between, the linear gain is the level divided by 127. The counter never jumps to a new setting. It climbs or falls by one level at a time toward a target, and it waits eight sample strobes between moves. A complete sweep therefore spreads over roughly 1024 sample periods, which avoids audible clicks.

The target comes from one of two sources, chosen by a mode input. In pin mode, the target follows a soft-mute request: asserting the request drives the target to 0, and releasing it drives the target to 127. Muting and unmuting thus reuse the same ramp. In serial mode, the mute pin is ignored and the target is a 7-bit value captured on a load strobe, which serves as both the volume control and the mute mechanism.

Both channels are scaled by the same level on the same strobe. A status output shows when the level has arrived at its target.

Top module: `vol_ramp_atten`

## Requirements
- R1: While reset is held and directly after it, both sample outputs and out_valid are 0. The level counter starts at 0 and the target starts at 127, so at_target is 0 and the level then rises toward 127.
- R2: On a strobe at level D, each output sample is computed as follows. Let p = x*D. Let s = p + floor(p/128) + floor(p/16384). The output is floor((s+64)/128), written as a 16-bit signed value. D=127 returns x unchanged and D=0 returns 0.
- R3: The level changes only on an edge where smp_valid is 1, and by exactly one. While the level is moving in one direction, it steps on every 8th strobe.
- R4: Each step moves the level toward the target held before that edge. It never moves past the target.
- R5: The 3-bit strobe phase restarts from zero whenever the movement state changes between idle, rising and falling. A reversal therefore waits a full 8 strobes before the first step in the new direction.
- R6: When ser_mode is 0, the target becomes 0 on the edge after mute_req is seen high, and 127 on the edge after it is seen low. tgt_load and tgt_value have no effect.
- R7: When ser_mode is 1, a tgt_load pulse captures tgt_value as the target on that edge. mute_req has no effect, and the target holds between loads.
- R8: Left and right are scaled by the same level on the same strobe, so equal inputs give equal outputs.
- R9: at_target is 1 exactly when the level equals the target. Once there, the level stays put until the target changes.
- R10: out_valid is 1 in the cycle after each strobe and 0 otherwise. Outputs keep their last value between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | One-cycle strobe marking a new stereo sample |
| left_in | input | 16 | Left sample, two's complement |
| right_in | input | 16 | Right sample, two's complement |
| ser_mode | input | 1 | 1: target from load interface; 0: target from mute pin |
| mute_req | input | 1 | Soft-mute request (pin mode only) |
| tgt_load | input | 1 | Load strobe for tgt_value (serial mode only) |
| tgt_value | input | 7 | Target level, 127 = 0 dB, 0 = silent |
| left_out | output | 16 | Scaled left sample |
| right_out | output | 16 | Scaled right sample |
| out_valid | output | 1 | Marks new output samples |
| at_target | output | 1 | Level equals target |

## Verification
The assertions check local rules on every cycle:
- the level is still without a strobe, moves by at most one, never moves away from the target, and stays put once it arrives;
- the phase restarts on a change of direction;
- the pin-mode target follows the mute request, and a serial-mode target holds between loads;
- unity and zero gain, matching channels, and valid timing.

The exact step timing cannot be seen by a single property. This covers eight-strobe spacing under gapped strobes, the length of a full ramp, the delay after a reversal, and the rounding of every intermediate gain. Only the bench's cycle-by-cycle reference model shows these, across start-up, mute, unmute, serial loads and extreme samples.

// File: rtl/vol_pkg.sv
package vol_pkg;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_UP   = 2'd1,
    MV_DOWN = 2'd2
  } move_e;

  // Direction the level must take to reach the goal.
  function automatic move_e move_dir(input int unsigned level, input int unsigned goal);
    if (level < goal)      return MV_UP;
    else if (level > goal) return MV_DOWN;
    else                   return MV_IDLE;
  endfunction

endpackage

// File: rtl/vol_target_sel.sv
module vol_target_sel #(
  parameter int unsigned GAIN_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_mode,
  input  logic              mute_req,
  input  logic              tgt_load,
  input  logic [GAIN_W-1:0] tgt_value,
  output logic [GAIN_W-1:0] tgt_q
);
  localparam logic [GAIN_W-1:0] FULL = {GAIN_W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n)              tgt_q <= FULL;
    else if (!ser_mode)      tgt_q <= mute_req ? '0 : FULL;
    else if (tgt_load)       tgt_q <= tgt_value;
  end

  // R6
  pin_mute_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && mute_req) |=> (tgt_q == '0));
  // R6
  pin_release_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ser_mode && !mute_req) |=> (tgt_q == FULL));
  // R7
  ser_hold_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && !tgt_load) |=> $stable(tgt_q));
  // R7
  ser_load_tgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_mode && tgt_load) |=> (tgt_q == $past(tgt_value)));

endmodule

// File: rtl/vol_ramp_ctr.sv
module vol_ramp_ctr
  import vol_pkg::*;
#(
  parameter int unsigned GAIN_W   = 7,
  parameter int unsigned STEP_SMP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [GAIN_W-1:0] tgt,
  output logic [GAIN_W-1:0] gain_q,
  output logic              at_target,
  output logic              step_evt,
  output logic              dir_flip
);
  localparam int unsigned PH_W = (STEP_SMP > 2) ? $clog2(STEP_SMP) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(STEP_SMP - 1);

  move_e           mv, mv_q;
  logic [PH_W-1:0] ph_q, ph_eff, ph_nxt;

  always_comb begin
    mv       = move_dir(32'(gain_q), 32'(tgt));
    dir_flip = (mv != mv_q);
    ph_eff   = dir_flip ? '0 : ph_q;
    step_evt = smp_valid && (mv != MV_IDLE) && (ph_eff == PH_LAST);
    if (mv == MV_IDLE)    ph_nxt = '0;
    else if (smp_valid)   ph_nxt = (ph_eff == PH_LAST) ? '0 : ph_eff + 1'b1;
    else                  ph_nxt = ph_eff;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gain_q <= '0;
      mv_q   <= MV_IDLE;
      ph_q   <= '0;
    end else begin
      mv_q <= mv;
      ph_q <= ph_nxt;
      if (step_evt) gain_q <= (mv == MV_UP) ? gain_q + 1'b1 : gain_q - 1'b1;
    end
  end

  assign at_target = (gain_q == tgt);

  // R3
  no_strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(gain_q));
  // R3
  unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, gain_q} == {1'b0, $past(gain_q)}) ||
             ({1'b0, gain_q} == {1'b0, $past(gain_q)} + 1'b1) ||
             ({1'b0, gain_q} + 1'b1 == {1'b0, $past(gain_q)}));
  // R4
  toward_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q < tgt) |=> (gain_q >= $past(gain_q) && gain_q <= $past(tgt)));
  // R4
  toward_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_q > tgt) |=> (gain_q <= $past(gain_q) && gain_q >= $past(tgt)));
  // R9
  settled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_target |=> $stable(gain_q));
  // R5
  flip_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_flip |=> (ph_q <= PH_W'(1)));

endmodule

// File: rtl/vol_scaler.sv
module vol_scaler #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned GAIN_W = 7
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [GAIN_W-1:0]        gain,
  input  logic signed [DATA_W-1:0] din,
  output logic signed [DATA_W-1:0] dout
);
  localparam int unsigned SW = DATA_W + GAIN_W + 2;
  localparam logic signed [SW-1:0] RND = SW'(1) <<< (GAIN_W - 1);

  // x * g / (2^GAIN_W - 1) via a short geometric series, rounded.
  function automatic logic signed [DATA_W-1:0] scale_smp(
    input logic signed [DATA_W-1:0] x, input logic [GAIN_W-1:0] g);
    logic signed [SW-1:0] p, s;
    p = SW'(x) * SW'($signed({1'b0, g}));
    s = p + (p >>> GAIN_W) + (p >>> (2 * GAIN_W)) + RND;
    return DATA_W'(s >>> GAIN_W);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)        dout <= '0;
    else if (in_valid) dout <= scale_smp(din, gain);
  end

  // R2
  unity_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == {GAIN_W{1'b1}}) |=> (dout == $past(din)));
  // R2
  zero_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain == '0) |=> (dout == '0));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(dout));

endmodule

// File: rtl/vol_ramp_atten.sv
module vol_ramp_atten #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned GAIN_W   = 7,
  parameter int unsigned STEP_SMP = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] left_in,
  input  logic [DATA_W-1:0] right_in,
  input  logic              ser_mode,
  input  logic              mute_req,
  input  logic              tgt_load,
  input  logic [GAIN_W-1:0] tgt_value,
  output logic [DATA_W-1:0] left_out,
  output logic [DATA_W-1:0] right_out,
  output logic              out_valid,
  output logic              at_target
);
  localparam int unsigned NUM_CH = 2;

  logic [GAIN_W-1:0] tgt_q, gain_q;
  logic              step_evt, dir_flip;
  logic [DATA_W-1:0] ch_in  [NUM_CH];
  logic [DATA_W-1:0] ch_out [NUM_CH];

  vol_target_sel #(.GAIN_W(GAIN_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .mute_req(mute_req),
    .tgt_load(tgt_load), .tgt_value(tgt_value), .tgt_q(tgt_q)
  );

  vol_ramp_ctr #(.GAIN_W(GAIN_W), .STEP_SMP(STEP_SMP)) u_ramp (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .tgt(tgt_q),
    .gain_q(gain_q), .at_target(at_target), .step_evt(step_evt), .dir_flip(dir_flip)
  );

  assign ch_in[0]  = left_in;
  assign ch_in[1]  = right_in;
  assign left_out  = ch_out[0];
  assign right_out = ch_out[1];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vol_scaler #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scl (
      .clk(clk), .rst_n(rst_n), .in_valid(smp_valid), .gain(gain_q),
      .din(ch_in[c]), .dout(ch_out[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= smp_valid;
  end

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (out_valid == $past(smp_valid)));
  // R8
  twin_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && left_in == right_in) |=> (left_out == right_out));
  // R3
  step_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |-> (smp_valid && !at_target));

endmodule

// File: tb/vol_ramp_atten_test.sv
`timescale 1ns/1ps
module vol_ramp_atten_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stb = 1'b0, ser = 1'b0, mute = 1'b0, load = 1'b0;
  logic [6:0]  tval = '0;
  logic [15:0] l_in = '0, r_in = '0;
  logic [15:0] l_out, r_out;
  logic        o_valid, at_tgt;

  int n_chk = 0, n_fail = 0, k = 0;
  int m_d, m_t, m_ph, m_mvq, m_l, m_r, m_v;
  string cur_tag = "R1";

  always #2.5 clk = ~clk;

  vol_ramp_atten uut (
    .clk(clk), .rst_n(rst_n), .smp_valid(stb), .left_in(l_in), .right_in(r_in),
    .ser_mode(ser), .mute_req(mute), .tgt_load(load), .tgt_value(tval),
    .left_out(l_out), .right_out(r_out), .out_valid(o_valid), .at_target(at_tgt)
  );

  function automatic int fdiv(int a, int b);
    int q = a / b;
    if ((a % b) != 0 && a < 0) q = q - 1;
    return q;
  endfunction

  function automatic int ref_scale(int x, int d);
    int p = x * d;
    int s = p + fdiv(p, 128) + fdiv(p, 16384);
    return fdiv(s + 64, 128);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_d = 0; m_t = 127; m_ph = 0; m_mvq = 0; m_l = 0; m_r = 0; m_v = 0;
  endtask

  // Behavioural reference, applied once per rising edge.
  task automatic model_edge();
    int mv, eff;
    if (stb) begin
      m_l = ref_scale(int'($signed(l_in)), m_d);
      m_r = ref_scale(int'($signed(r_in)), m_d);
    end
    m_v = stb ? 1 : 0;
    mv  = (m_d < m_t) ? 1 : (m_d > m_t) ? 2 : 0;
    eff = (mv != m_mvq) ? 0 : m_ph;
    if (mv == 0) m_ph = 0;
    else if (stb) begin
      if (eff == 7) begin m_d = m_d + ((mv == 1) ? 1 : -1); m_ph = 0; end
      else m_ph = eff + 1;
    end else m_ph = eff;
    m_mvq = mv;
    if (!ser) m_t = mute ? 0 : 127;
    else if (load) m_t = int'(tval);
  endtask

  task automatic compare();
    chk(int'(o_valid) == m_v, {"R10 ", cur_tag}, int'(o_valid), m_v);
    chk(int'($signed(l_out)) == m_l, {"R2 left ", cur_tag}, int'($signed(l_out)), m_l);
    chk(int'($signed(r_out)) == m_r, {"R8 right ", cur_tag}, int'($signed(r_out)), m_r);
    chk(int'(at_tgt) == ((m_d == m_t) ? 1 : 0), {"R9 ", cur_tag}, int'(at_tgt), (m_d == m_t) ? 1 : 0);
  endtask

  // Inputs are already set at a falling edge; run one edge and check.
  task automatic cycle();
    @(posedge clk);
    if (rst_n) model_edge(); else model_reset();
    @(negedge clk);
    compare();
  endtask

  task automatic feed(int n, int gap);
    for (int i = 0; i < n; i++) begin
      for (int g = 0; g < gap; g++) begin
        stb = 1'b0;
        cycle();
      end
      stb = 1'b1;
      k++;
      l_in = 16'((k * 7919) % 65536);
      r_in = 16'((k * 104729 + 333) % 65536);
      cycle();
    end
    stb = 1'b0;
  endtask

  initial begin
    model_reset();
    @(negedge clk);
    // R1: reset state
    cycle(); cycle();
    chk(l_out == 16'd0 && r_out == 16'd0, "R1 outputs", int'(l_out), 0);
    chk(o_valid == 1'b0 && at_tgt == 1'b0, "R1 flags", int'(at_tgt), 0);
    rst_n = 1'b1;

    // R6 / R3: start-up ramp 0 -> 127 in pin mode
    cur_tag = "R3 startup";
    feed(1030, 0);
    chk(at_tgt == 1'b1, "R6 release reached full", int'(at_tgt), 1);

    // R6 / R5: mute part way, then reverse
    cur_tag = "R6 mute";
    mute = 1'b1;
    feed(300, 0);
    chk(at_tgt == 1'b0, "R6 mute still ramping", int'(at_tgt), 0);
    cur_tag = "R5 reversal";
    mute = 1'b0;
    feed(320, 1);
    chk(at_tgt == 1'b1, "R5 back at full", int'(at_tgt), 1);

    // R6: load interface ignored in pin mode
    cur_tag = "R6 load ignored";
    tval = 7'd10; load = 1'b1;
    feed(20, 0);
    load = 1'b0;
    chk(at_tgt == 1'b1, "R6 target unchanged", int'(at_tgt), 1);
    chk(l_out == l_in, "R6 unity after ignored load", int'(l_out), int'(l_in));

    // R7: serial mode load, strobes with gaps
    cur_tag = "R7 serial";
    ser = 1'b1;
    tval = 7'd64; load = 1'b1; cycle(); load = 1'b0;
    feed(520, 2);
    chk(at_tgt == 1'b1, "R7 reached 64", int'(at_tgt), 1);

    // R7: mute pin ignored in serial mode
    cur_tag = "R7 mute ignored";
    mute = 1'b1;
    feed(40, 0);
    chk(at_tgt == 1'b1, "R7 mute pin no effect", int'(at_tgt), 1);
    mute = 1'b0;

    // R3: exact spacing, two steps need 16 strobes
    cur_tag = "R3 spacing";
    tval = 7'd66; load = 1'b1; cycle(); load = 1'b0;
    feed(15, 0);
    chk(at_tgt == 1'b0, "R3 not there after 15 strobes", int'(at_tgt), 0);
    feed(1, 0);
    chk(at_tgt == 1'b1, "R3 there after 16 strobes", int'(at_tgt), 1);

    // R2: extremes at unity gain
    cur_tag = "R2 extremes";
    tval = 7'd127; load = 1'b1; cycle(); load = 1'b0;
    feed(500, 0);
    l_in = 16'h7FFF; r_in = 16'h8000; stb = 1'b1; cycle(); stb = 1'b0;
    chk(l_out == 16'h7FFF, "R2 max at unity", int'($signed(l_out)), 32767);
    chk(r_out == 16'h8000, "R2 min at unity", int'($signed(r_out)), -32768);

    // R2 / R4: ramp to silence, zero output
    cur_tag = "R4 to zero";
    tval = 7'd0; load = 1'b1; cycle(); load = 1'b0;
    feed(1030, 0);
    l_in = 16'h7FFF; r_in = 16'h8000; stb = 1'b1; cycle(); stb = 1'b0;
    chk(l_out == 16'd0 && r_out == 16'd0, "R2 zero gain", int'($signed(l_out)), 0);

    // R8: equal inputs at a mid gain
    cur_tag = "R8 twin";
    tval = 7'd45; load = 1'b1; cycle(); load = 1'b0;
    feed(400, 0);
    l_in = 16'hC123; r_in = 16'hC123; stb = 1'b1; cycle(); stb = 1'b0;
    chk(l_out == r_out, "R8 equal channels", int'(l_out), int'(r_out));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule